// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block models the lookup side of a small cache and explains every access it sees. A stream of byte addresses enters through a valid/ready port. For each accepted address the block tells whether the model cache hit, missed into an empty line, or missed and displaced a valid line. Every miss also gets a cause: first reference to the block (compulsory), a miss that a fully associative cache of the same size with LRU replacement would not have taken (conflict), or a miss that such a cache would also have taken (capacity).

Three structures run side by side. The first is the tag/valid array of the real cache, either direct-mapped or 2-way with per-set LRU. The second is a shadow fully associative LRU list holding as many blocks as the real cache. The third is a bitmap with one bit per block of the address space that records first touches. Four saturating counters tally hits and the three miss causes. They can be read at any time. No data is stored, and no refill or write policy is modelled.

Back-pressure works as follows. The result port holds one entry. An access is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the result register is empty or is being drained in the same cycle (`res_ready` high). While `res_valid` is high and `res_ready` is low, the result fields stay frozen and no new access is taken.

Top module: `cmc_classifier`

## Requirements
- R1: An address splits into offset (low log2(BLOCK_BYTES) bits), set index (next log2(sets) bits) and tag (remaining high bits). The number of sets is (CACHE_BYTES/BLOCK_BYTES)/WAYS. The defaults are an 8-bit address, a 32-byte cache, 8-byte blocks and direct mapping, so the index is address bits [4:3].
- R2: `res_outcome` is 0 (hit) when a valid line in the indexed set holds the tag. It is 1 (miss into an empty line) or 2 (miss that evicts a valid line) otherwise. The value 3 is never produced.
- R3: On a miss the chosen line is filled with the new tag and marked valid. The outcome is 2 exactly when that line was valid before the fill.
- R4: With WAYS=2 the fill goes to the lowest-numbered invalid way of the set. If both ways are valid, it goes to the least recently used way. Every hit and every fill makes the touched way the most recently used.
- R5: `res_kind` is 1 (compulsory) for a miss on a block not referenced since reset. This holds even when every line is valid.
- R6: A miss on a block seen before has `res_kind` 2 (conflict) when the shadow fully associative LRU list of equal block count holds the block, and 3 (capacity) when it does not. Every access, hit or miss, moves its block to the front of that list, and a full list drops its oldest entry.
- R7: A hit reports `res_kind` 0.
- R8: Each accepted access yields exactly one result, in order, with `res_addr` equal to the accepted address. The result is valid on the cycle after acceptance and holds stable while `res_ready` is low. `in_ready` is low while a result waits with `res_ready` low.
- R9: `cnt_hit`, `cnt_compulsory`, `cnt_conflict` and `cnt_capacity` each add one per accepted access of their kind and stop at their all-ones value.
- R10: Reset clears all valid bits, the first-touch bitmap, the shadow list, the counters and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block can take an address this cycle |
| in_addr | input | ADDR_W | Byte address |
| res_valid | output | 1 | Result held in the output register |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_addr | output | ADDR_W | Address the result belongs to |
| res_outcome | output | 2 | 0 hit, 1 miss into empty line, 2 miss with eviction |
| res_kind | output | 2 | 0 hit, 1 compulsory, 2 conflict, 3 capacity |
| cnt_hit | output | CNT_W | Saturating hit count |
| cnt_compulsory | output | CNT_W | Saturating compulsory miss count |
| cnt_conflict | output | CNT_W | Saturating conflict miss count |
| cnt_capacity | output | CNT_W | Saturating capacity miss count |

## Verification
The bench replays a short address trace on a direct-mapped instance and a 2-way instance together. In that trace the shadow list must have dropped a block, so a block that the real cache lost to a conflict reappears as a capacity miss. A design that kept the shadow list too long, or updated it only on misses, would call those misses conflict. The same trace hits a re-touched block in a set whose other way is older, so a 2-way victim choice that ignored recency would evict the wrong line and turn a later hit into a miss. A random phase with random back-pressure checks that results are neither dropped nor duplicated and stay frozen while stalled. A 3-bit counter instance must stop at 7 instead of wrapping to 0. A mid-run reset must make previously seen blocks compulsory again; a bitmap that survived reset would report them as capacity misses.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    OUT_HIT   = 2'd0,
    OUT_FILL  = 2'd1,
    OUT_EVICT = 2'd2
  } outcome_e;

  typedef enum logic [1:0] {
    K_HIT        = 2'd0,
    K_COMPULSORY = 2'd1,
    K_CONFLICT   = 2'd2,
    K_CAPACITY   = 2'd3
  } kind_e;
endpackage

// File: rtl/cmc_real_cache.sv
module cmc_real_cache #(
  parameter int BLKA_W = 5,
  parameter int SETS   = 4,
  parameter int WAYS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLKA_W-1:0] lk_blk,
  input  logic              upd,
  output logic              hit,
  output logic              evict
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = BLKA_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  vld [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] vic;

  assign idx = lk_blk[IDX_W-1:0];
  assign tag = lk_blk[BLKA_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld[idx][w] && (tags[idx][w] == tag);
  end

  assign hit   = |way_hit;
  assign evict = !hit && vld[idx][vic];

  if (WAYS == 1) begin : g_dm
    assign vic = '0;
  end else begin : g_2w
    logic             lru_q [SETS];
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] use_way;

    always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
        if (way_hit[w]) hit_way = WAY_W'(w);
    end

    always_comb begin
      if (!vld[idx][0])      vic = 1'b0;
      else if (!vld[idx][1]) vic = 1'b1;
      else                   vic = lru_q[idx];
    end

    assign use_way = hit ? hit_way : vic;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
      end else if (upd) begin
        lru_q[idx] <= ~use_way[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (upd && !hit) begin
      vld[idx][vic] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd && !hit) tags[idx][vic] <= tag;
  end
endmodule

// File: rtl/cmc_shadow_lru.sv
module cmc_shadow_lru #(
  parameter int BLKA_W = 5,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLKA_W-1:0] blk,
  input  logic              upd,
  output logic              hit
);
  logic [BLKA_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0]  occ;
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  at_or_after;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = occ[i] && (ent[i] == blk);
  end

  assign hit = |match;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      acc = acc | match[i];
      at_or_after[i] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (upd) begin
      occ[0] <= 1'b1;
      for (int i = 1; i < DEPTH; i++)
        if (!hit || at_or_after[i]) occ[i] <= occ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      ent[0] <= blk;
      for (int i = 1; i < DEPTH; i++)
        if (!hit || at_or_after[i]) ent[i] <= ent[i-1];
    end
  end
endmodule

// File: rtl/cmc_touch_map.sv
module cmc_touch_map #(
  parameter int BLKA_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLKA_W-1:0] blk,
  input  logic              upd,
  output logic              seen
);
  localparam int NBLK_ALL = 1 << BLKA_W;

  logic [NBLK_ALL-1:0] map_q;

  assign seen = map_q[blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   map_q <= '0;
    else if (upd) map_q[blk] <= 1'b1;
  end
endmodule

// File: rtl/cmc_counters.sv
module cmc_counters #(
  parameter int NUM   = 4,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (inc[i] && (cnt[i] != {CNT_W{1'b1}}))
        cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/cmc_classifier.sv
module cmc_classifier #(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_BYTES = 8,
  parameter int CACHE_BYTES = 32,
  parameter int WAYS        = 1,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [1:0]        res_outcome,
  output logic [1:0]        res_kind,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_compulsory,
  output logic [CNT_W-1:0]  cnt_conflict,
  output logic [CNT_W-1:0]  cnt_capacity
);
  import cmc_pkg::*;

  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int NBLK   = CACHE_BYTES / BLOCK_BYTES;
  localparam int SETS   = NBLK / WAYS;
  localparam int BLKA_W = ADDR_W - OFF_W;

  logic              fire;
  logic [BLKA_W-1:0] blk;
  logic              rc_hit, rc_evict, sh_hit, seen;
  kind_e             kind;
  outcome_e          outcome;
  logic [3:0]        inc;
  logic [3:0][CNT_W-1:0] cnt;

  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;
  assign blk      = in_addr[ADDR_W-1:OFF_W];

  cmc_real_cache #(.BLKA_W(BLKA_W), .SETS(SETS), .WAYS(WAYS)) u_real (
    .clk(clk), .rst_n(rst_n), .lk_blk(blk), .upd(fire),
    .hit(rc_hit), .evict(rc_evict)
  );

  cmc_shadow_lru #(.BLKA_W(BLKA_W), .DEPTH(NBLK)) u_shadow (
    .clk(clk), .rst_n(rst_n), .blk(blk), .upd(fire), .hit(sh_hit)
  );

  cmc_touch_map #(.BLKA_W(BLKA_W)) u_touch (
    .clk(clk), .rst_n(rst_n), .blk(blk), .upd(fire), .seen(seen)
  );

  always_comb begin
    if (rc_hit)      kind = K_HIT;
    else if (!seen)  kind = K_COMPULSORY;
    else if (sh_hit) kind = K_CONFLICT;
    else             kind = K_CAPACITY;
    if (rc_hit)        outcome = OUT_HIT;
    else if (rc_evict) outcome = OUT_EVICT;
    else               outcome = OUT_FILL;
  end

  assign inc = fire ? (4'b0001 << kind) : 4'b0000;

  cmc_counters #(.NUM(4), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cnt(cnt)
  );

  assign cnt_hit        = cnt[0];
  assign cnt_compulsory = cnt[1];
  assign cnt_conflict   = cnt[2];
  assign cnt_capacity   = cnt[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else if (fire) begin
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      res_addr    <= in_addr;
      res_outcome <= outcome;
      res_kind    <= kind;
    end
  end
endmodule

// File: rtl/cmc_classifier_chk.sv
module cmc_classifier_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_addr,
  input logic [1:0]        res_outcome,
  input logic [1:0]        res_kind,
  input logic [CNT_W-1:0]  cnt_hit,
  input logic [CNT_W-1:0]  cnt_conflict
);
  assert_outcome_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_outcome != 2'd3);

  assert_empty_fill_compulsory_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_outcome == 2'd1) |-> res_kind == 2'd1);

  assert_hit_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_outcome == 2'd0) |-> res_kind == 2'd0);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_addr)
      && $stable(res_outcome) && $stable(res_kind));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hit == {CNT_W{1'b1}}) |=> (cnt_hit == {CNT_W{1'b1}}));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> cnt_conflict >= $past(cnt_conflict));

  assert_reset_empty_R10: assert property (@(posedge clk)
    !rst_n |-> !res_valid);
endmodule

bind cmc_classifier cmc_classifier_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cmc_classifier_tb.sv
module cmc_classifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_addr = '0;
  logic res_ready = 1'b1;

  logic in_ready_a, res_valid_a, in_ready_b, res_valid_b;
  logic [7:0] res_addr_a, res_addr_b;
  logic [1:0] out_a, kind_a, out_b, kind_b;
  logic [15:0] ch_a, cc_a, cf_a, cp_a;
  logic [2:0]  ch_b, cc_b, cf_b, cp_b;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cmc_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
    .in_addr(in_addr), .res_valid(res_valid_a), .res_ready(res_ready),
    .res_addr(res_addr_a), .res_outcome(out_a), .res_kind(kind_a),
    .cnt_hit(ch_a), .cnt_compulsory(cc_a), .cnt_conflict(cf_a), .cnt_capacity(cp_a)
  );

  cmc_classifier #(.WAYS(2), .CNT_W(3)) u_dut_2way (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_addr(in_addr), .res_valid(res_valid_b), .res_ready(res_ready),
    .res_addr(res_addr_b), .res_outcome(out_b), .res_kind(kind_b),
    .cnt_hit(ch_b), .cnt_compulsory(cc_b), .cnt_conflict(cf_b), .cnt_capacity(cp_b)
  );

  // reference model, index 0 = direct-mapped, 1 = 2-way
  bit mv [2][4][2];
  int mt [2][4][2];
  int mlru [2][4];
  int shl [2][4];
  int shn [2];
  bit touched [2][32];
  int tally [2][4];
  logic [11:0] expq0 [$];
  logic [11:0] expq1 [$];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        mlru[m][s] = 0;
        for (int w = 0; w < 2; w++) begin mv[m][s][w] = 0; mt[m][s][w] = 0; end
      end
      shn[m] = 0;
      for (int b = 0; b < 32; b++) touched[m][b] = 0;
      for (int k = 0; k < 4; k++) tally[m][k] = 0;
    end
  endtask

  task automatic model_access(input int m, input int a);
    int blk, ways, sets, set, tag, hitw, vic, p, n, outc, kind;
    bit comp;
    blk = a >> 3; ways = m + 1; sets = 4 / ways;
    set = blk % sets; tag = blk / sets;
    hitw = -1;
    for (int w = 0; w < ways; w++) if (mv[m][set][w] && mt[m][set][w] == tag) hitw = w;
    p = -1;
    for (int i = 0; i < shn[m]; i++) if (shl[m][i] == blk) p = i;
    comp = !touched[m][blk];
    if (hitw >= 0) begin
      outc = 0; kind = 0; vic = hitw;
    end else begin
      if (ways == 1) vic = 0;
      else if (!mv[m][set][0]) vic = 0;
      else if (!mv[m][set][1]) vic = 1;
      else vic = mlru[m][set];
      outc = mv[m][set][vic] ? 2 : 1;
      mv[m][set][vic] = 1; mt[m][set][vic] = tag;
      kind = comp ? 1 : ((p >= 0) ? 2 : 3);
    end
    if (ways == 2) mlru[m][set] = 1 - vic;
    if (p >= 0) begin
      for (int i = p; i > 0; i--) shl[m][i] = shl[m][i-1];
    end else begin
      n = (shn[m] < 4) ? shn[m] + 1 : 4;
      for (int i = n - 1; i > 0; i--) shl[m][i] = shl[m][i-1];
      shn[m] = n;
    end
    shl[m][0] = blk; touched[m][blk] = 1; tally[m][kind]++;
    if (m == 0) expq0.push_back({8'(a), 2'(outc), 2'(kind)});
    else        expq1.push_back({8'(a), 2'(outc), 2'(kind)});
  endtask

  // driver: called at posedge+2, returns at posedge+2 after acceptance
  task automatic send(input int a, input bit rand_bp);
    if (rand_bp) res_ready = ($urandom % 4) != 0;
    in_valid = 1'b1; in_addr = 8'(a);
    forever begin
      @(negedge clk);
      if (in_ready_a) break;
      @(posedge clk); #2; res_ready = 1'b1;
    end
    chk(in_ready_a == in_ready_b, "R8 ready agreement", in_ready_b, in_ready_a);
    model_access(0, a);
    model_access(1, a);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    res_ready = 1'b1;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check_counters();
    chk(ch_a == 16'(tally[0][0]), "R9 dm hit count", ch_a, tally[0][0]);
    chk(cc_a == 16'(tally[0][1]), "R9 dm compulsory count", cc_a, tally[0][1]);
    chk(cf_a == 16'(tally[0][2]), "R9 dm conflict count", cf_a, tally[0][2]);
    chk(cp_a == 16'(tally[0][3]), "R9 dm capacity count", cp_a, tally[0][3]);
    chk(ch_b == 3'((tally[1][0] > 7) ? 7 : tally[1][0]), "R9 2way hit count sat", ch_b, tally[1][0]);
    chk(cc_b == 3'((tally[1][1] > 7) ? 7 : tally[1][1]), "R9 2way comp count sat", cc_b, tally[1][1]);
    chk(cf_b == 3'((tally[1][2] > 7) ? 7 : tally[1][2]), "R9 2way conf count sat", cf_b, tally[1][2]);
    chk(cp_b == 3'((tally[1][3] > 7) ? 7 : tally[1][3]), "R9 2way cap count sat", cp_b, tally[1][3]);
  endtask

  // monitor: scoreboard pops on each transfer
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid_a && res_ready) begin
        if (expq0.size() == 0) chk(1'b0, "R8 dm unexpected result", res_addr_a, -1);
        else begin
          logic [11:0] e;
          e = expq0.pop_front();
          chk(res_addr_a == e[11:4], "R8 dm result order", res_addr_a, e[11:4]);
          chk(out_a == e[3:2], "R1 R2 R3 dm outcome", out_a, e[3:2]);
          chk(kind_a == e[1:0], "R5 R6 R7 dm kind", kind_a, e[1:0]);
        end
      end
      if (res_valid_b && res_ready) begin
        if (expq1.size() == 0) chk(1'b0, "R8 2way unexpected result", res_addr_b, -1);
        else begin
          logic [11:0] e;
          e = expq1.pop_front();
          chk(res_addr_b == e[11:4], "R8 2way result order", res_addr_b, e[11:4]);
          chk(out_b == e[3:2], "R4 R3 2way outcome", out_b, e[3:2]);
          chk(kind_b == e[1:0], "R5 R6 R7 2way kind", kind_b, e[1:0]);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int trace [9] = '{8'h04, 8'h05, 8'h68, 8'hC8, 8'h68, 8'hDD, 8'h45, 8'h04, 8'hC8};
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    chk(!res_valid_a && !res_valid_b, "R10 reset res_valid", res_valid_a, 0);
    chk(ch_a == 0 && cc_a == 0 && cf_a == 0 && cp_a == 0, "R10 reset counters", ch_a + cc_a, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready_a && in_ready_b, "R8 ready after reset", in_ready_a, 1);
    @(posedge clk); #2;

    // known trace: hand-derived tallies
    foreach (trace[i]) send(trace[i], 1'b0);
    idle(3);
    chk(ch_a == 1 && cc_a == 5, "R5 R7 dm trace hits/compulsory", ch_a * 10 + cc_a, 15);
    chk(cf_a == 1 && cp_a == 2, "R6 dm trace conflict/capacity", cf_a * 10 + cp_a, 12);
    chk(ch_b == 3 && cc_b == 5, "R4 R7 2way trace hits/compulsory", ch_b * 10 + cc_b, 35);
    chk(cf_b == 0 && cp_b == 1, "R6 2way trace conflict/capacity", cf_b * 10 + cp_b, 1);

    // explicit stall
    res_ready = 1'b0;
    in_valid = 1'b1; in_addr = 8'h10;
    @(negedge clk);
    chk(in_ready_a, "R8 accept into empty output", in_ready_a, 1);
    model_access(0, 8'h10); model_access(1, 8'h10);
    @(posedge clk); #2;
    in_addr = 8'h30;
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready_a && res_valid_a && res_addr_a == 8'h10, "R8 stall holds", res_addr_a, 8'h10);
      @(posedge clk); #2;
    end
    res_ready = 1'b1;
    @(negedge clk);
    chk(in_ready_a, "R8 release", in_ready_a, 1);
    model_access(0, 8'h30); model_access(1, 8'h30);
    @(posedge clk); #2;
    in_valid = 1'b0;
    idle(3);

    // random traffic with random back-pressure
    for (int i = 0; i < 400; i++) send(int'($urandom % 256), 1'b1);
    idle(4);
    chk(expq0.size() == 0 && expq1.size() == 0, "R8 all results delivered", expq0.size(), 0);
    check_counters();

    // mid-run reset: history forgotten
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk(!res_valid_a && ch_a == 0 && cp_a == 0, "R10 mid-run reset", ch_a, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
    send(8'h04, 1'b0);
    send(8'hC8, 1'b0);
    idle(3);
    chk(cc_a == 2 && cc_b == 2, "R10 R5 compulsory after reset", cc_a, 2);
    check_counters();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule